// File: doc/BRIEF.md
# DDR2 Refresh and Power-State Exit Timer

This block sits beside the command scheduler of a DDR2 memory controller. It counts out the average refresh interval and raises a refresh request whenever at least one refresh is owed. It also applies the mandatory waits after the clock enable returns high, so the scheduler knows when any command may go out and when a read may go out. The interval is shorter when the device runs in the extended temperature range. Up to a fixed number of refreshes can be postponed, and the block keeps that count internally.

The scheduler reports each power-state entry through a command strobe with a command kind. The block latches the kind of exit that will follow. On the first clock edge that samples the clock enable high again, it loads the matching non-read and read waits. A separate monitor flags any clock-enable level that lasted fewer than the minimum number of cycles.

Top module: `ddr2_refresh_exit_timer`

## Requirements
- R1: While reset is asserted, all four outputs are low and no refresh is owed. The sampled clock enable resets to low, so a high clock enable at the end of reset is handled as a fast power-down exit.
- R2: A refresh comes due every floor(7.8 us / clock period) cycles when `temp_ext` is 0, and every floor(3.9 us / clock period) cycles when it is 1. With a 20 ns clock that is 390 and 195 cycles. The length of each new interval follows `temp_ext` at the edge where the previous interval ends. The first interval starts at reset release.
- R3: `ref_req` is high exactly when a refresh is owed and `cmd_ok` is high. Each edge where `ref_ack` and `ref_req` are both high removes one owed refresh. `ref_ack` has no effect while `ref_req` is low.
- R4: No more than 8 refreshes are owed at once. Interval ends beyond that are dropped.
- R5: While the clock enable is low, `ref_req` stays low. The interval counter keeps running and owed refreshes keep accumulating.
- R6: `cmd_ok` is low whenever the sampled clock enable is low. When `cmd_valid` is high, `cmd_kind` selects the next exit type: 2 means self-refresh, 3 means precharge or fast active power-down, and 4 means slow active power-down. Kinds 0 (other) and 1 (read) do not change the exit type.
- R7: Let E be the first edge that samples the clock enable high after a self-refresh. A non-read command is allowed from edge E+ceil((105 ns + 10 ns) / clock period) onward, which is E+6 at 20 ns. A read is allowed from edge E+200 onward.
- R8: After a precharge or fast power-down exit, both reads and other commands are allowed from edge E+2 onward.
- R9: After a slow power-down exit, a read is allowed from edge E+max(6 - `add_lat`, 1) onward. `rd_ok` is never high unless `cmd_ok` is high.
- R10: A clock-enable level that was sampled on fewer than 3 consecutive edges before it changed makes `cke_viol` high for exactly one cycle after the edge that samples the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| temp_ext | input | 1 | 1 selects the extended-temperature refresh interval |
| add_lat | input | 3 | Additive latency in cycles, 0 to 5 |
| cke | input | 1 | Clock enable as driven to the memory |
| cmd_valid | input | 1 | A command is issued this cycle |
| cmd_kind | input | 3 | Kind of the issued command (see R6) |
| ref_ack | input | 1 | Scheduler issues a refresh for the pending request |
| ref_req | output | 1 | At least one refresh is owed and may be issued |
| cmd_ok | output | 1 | A command other than NOP or deselect may be issued at the next edge |
| rd_ok | output | 1 | A read may be issued at the next edge |
| cke_viol | output | 1 | One-cycle flag for a clock-enable pulse that was too short |

## Verification
The assertions assume the following about the inputs:
- `add_lat` stays at 5 or below.
- `ref_ack` is raised only while a request is visible.
- The power-down waits are at least two cycles, so the cycle after a clock-enable rise is always blocked.

The stimulus keeps every clock-enable level for three or more cycles, except in the deliberate short-pulse case. It changes `add_lat` and `cmd_kind` only while the clock enable is high, before an entry command. It acknowledges only while `ref_req` is observed high.

// File: rtl/ddr2_refresh_exit_timer.sv
module ddr2_refresh_exit_timer #(
  parameter int CLK_PS        = 20000,
  parameter int REFI_NORM_PS  = 7800000,
  parameter int REFI_EXT_PS   = 3900000,
  parameter int RFC_PS        = 105000,
  parameter int SR_MARGIN_PS  = 10000,
  parameter int SR_RD_CYC     = 200,
  parameter int PD_EXIT_CYC   = 2,
  parameter int SLOW_RD_BASE  = 6,
  parameter int CKE_MIN_CYC   = 3,
  parameter int MAX_OWED      = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       temp_ext,
  input  logic [2:0] add_lat,
  input  logic       cke,
  input  logic       cmd_valid,
  input  logic [2:0] cmd_kind,
  input  logic       ref_ack,
  output logic       ref_req,
  output logic       cmd_ok,
  output logic       rd_ok,
  output logic       cke_viol
);

  localparam int REFI_N_CYC = REFI_NORM_PS / CLK_PS;
  localparam int REFI_E_CYC = REFI_EXT_PS / CLK_PS;
  localparam int SR_NR_CYC  = (RFC_PS + SR_MARGIN_PS + CLK_PS - 1) / CLK_PS;
  localparam int MAX_A      = (SR_RD_CYC > SR_NR_CYC) ? SR_RD_CYC : SR_NR_CYC;
  localparam int MAX_B      = (PD_EXIT_CYC > SLOW_RD_BASE) ? PD_EXIT_CYC : SLOW_RD_BASE;
  localparam int EXIT_MAX   = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int IVL_W      = $clog2(REFI_N_CYC + 1);
  localparam int EXIT_W     = $clog2(EXIT_MAX + 1);
  localparam int OWE_W      = $clog2(MAX_OWED + 1);
  localparam int RUN_W      = $clog2(CKE_MIN_CYC + 1);

  localparam logic [1:0] X_FAST = 2'd0;
  localparam logic [1:0] X_SLOW = 2'd1;
  localparam logic [1:0] X_SELF = 2'd2;

  logic [IVL_W-1:0]  ivl;
  logic [OWE_W-1:0]  owed;
  logic [EXIT_W-1:0] nr_cnt, rd_cnt, nr_len, rd_len, slow_rd;
  logic [RUN_W-1:0]  run;
  logic [1:0]        exit_kind;
  logic              cke_q;

  wire tick  = (ivl == '0);
  wire take  = ref_ack && ref_req;
  wire waken = cke && !cke_q;

  assign cmd_ok  = cke_q && (nr_cnt == '0);
  assign rd_ok   = cmd_ok && (rd_cnt == '0);
  assign ref_req = cmd_ok && (owed != '0);

  // refresh interval and owed count
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ivl  <= IVL_W'(REFI_N_CYC - 1);
      owed <= '0;
    end else begin
      if (tick) ivl <= temp_ext ? IVL_W'(REFI_E_CYC - 1) : IVL_W'(REFI_N_CYC - 1);
      else      ivl <= ivl - IVL_W'(1);
      if (tick && !take) begin
        if (owed < OWE_W'(MAX_OWED)) owed <= owed + OWE_W'(1);
      end else if (take && !tick) begin
        owed <= owed - OWE_W'(1);
      end
    end
  end

  // exit type latch
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) exit_kind <= X_FAST;
    else if (cmd_valid) begin
      case (cmd_kind)
        3'd2:    exit_kind <= X_SELF;
        3'd3:    exit_kind <= X_FAST;
        3'd4:    exit_kind <= X_SLOW;
        default: exit_kind <= exit_kind;
      endcase
    end
  end

  always_comb begin
    int w;
    w = SLOW_RD_BASE - int'(add_lat);
    if (w < 1) w = 1;
    slow_rd = EXIT_W'(w);
  end

  always_comb begin
    case (exit_kind)
      X_SELF:  begin nr_len = EXIT_W'(SR_NR_CYC);   rd_len = EXIT_W'(SR_RD_CYC);   end
      X_SLOW:  begin nr_len = EXIT_W'(PD_EXIT_CYC); rd_len = slow_rd;              end
      default: begin nr_len = EXIT_W'(PD_EXIT_CYC); rd_len = EXIT_W'(PD_EXIT_CYC); end
    endcase
  end

  // exit wait counters
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nr_cnt <= '0;
      rd_cnt <= '0;
    end else if (waken) begin
      nr_cnt <= nr_len - EXIT_W'(1);
      rd_cnt <= rd_len - EXIT_W'(1);
    end else begin
      if (nr_cnt != '0) nr_cnt <= nr_cnt - EXIT_W'(1);
      if (rd_cnt != '0) rd_cnt <= rd_cnt - EXIT_W'(1);
    end
  end

  // clock-enable pulse width monitor
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cke_q    <= 1'b0;
      run      <= RUN_W'(CKE_MIN_CYC);
      cke_viol <= 1'b0;
    end else begin
      cke_q <= cke;
      if (cke != cke_q) begin
        cke_viol <= (run < RUN_W'(CKE_MIN_CYC));
        run      <= RUN_W'(1);
      end else begin
        cke_viol <= 1'b0;
        if (run < RUN_W'(CKE_MIN_CYC)) run <= run + RUN_W'(1);
      end
    end
  end

  p_req_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ref_req |-> cmd_ok);
  p_owed_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    owed <= OWE_W'(MAX_OWED));
  p_req_after_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ref_req |-> $past(cke));
  p_exit_blocked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cke && !$past(cke)) |=> !cmd_ok);
  p_rd_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ok |-> cmd_ok);
  p_viol_on_change_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cke_viol |-> ($past(cke) != $past(cke, 2)));

endmodule

// File: tb/tb_ddr2_refresh_exit_timer.sv
`timescale 1ns/1ps
module tb_ddr2_refresh_exit_timer;
  logic clk = 0, rst_n = 0, temp_ext = 0, cke = 1, cmd_valid = 0, ref_ack = 0;
  logic [2:0] add_lat = 0, cmd_kind = 0;
  logic ref_req, cmd_ok, rd_ok, cke_viol;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  ddr2_refresh_exit_timer dut (
    .clk(clk), .rst_n(rst_n), .temp_ext(temp_ext), .add_lat(add_lat), .cke(cke),
    .cmd_valid(cmd_valid), .cmd_kind(cmd_kind), .ref_ack(ref_ack),
    .ref_req(ref_req), .cmd_ok(cmd_ok), .rd_ok(rd_ok), .cke_viol(cke_viol));

  // {entry kind, add_lat, non-read wait, read wait as seen with gating}
  localparam int VEC [6][4] = '{
    '{2, 0, 6, 200}, '{3, 0, 2, 2}, '{4, 0, 2, 6},
    '{4, 2, 2, 4},   '{4, 4, 2, 2}, '{4, 5, 2, 2}};

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 0; cke = 1; ref_ack = 0; cmd_valid = 0; temp_ext = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic gap(output int n);
    ref_ack = 1;
    @(negedge clk);
    ref_ack = 0;
    n = 1;
    while (!ref_req && n < 1000) begin
      @(negedge clk);
      n++;
    end
  endtask

  initial begin
    int n, nr, rd, cnt, seen;
    rst_n = 0;
    repeat (2) @(negedge clk);
    check("R1 ref_req", ref_req, 0);
    check("R1 cmd_ok", cmd_ok, 0);
    check("R1 rd_ok", rd_ok, 0);
    check("R1 cke_viol", cke_viol, 0);
    rst_n = 1;
    @(negedge clk);
    check("R1 first high is exit", cmd_ok, 0);
    @(negedge clk);
    check("R1 fast exit done", cmd_ok, 1);
    repeat (4) @(negedge clk);

    // exit vector table (R6 R7 R8 R9)
    foreach (VEC[v]) begin
      add_lat = 3'(VEC[v][1]);
      cmd_valid = 1; cmd_kind = 3'(VEC[v][0]);
      @(negedge clk);
      cmd_valid = 0; cmd_kind = 0; cke = 0;
      repeat (4) @(negedge clk);
      check("R6 blocked while low", cmd_ok, 0);
      cke = 1;
      nr = 0; rd = 0;
      for (int i = 1; i <= 300; i++) begin
        @(negedge clk);
        if (nr == 0 && cmd_ok) nr = i;
        if (rd == 0 && rd_ok) rd = i;
        if (nr != 0 && rd != 0) break;
      end
      check(VEC[v][0] == 2 ? "R7 non-read wait" : "R8 non-read wait", nr, VEC[v][2]);
      check(VEC[v][0] == 4 ? "R9 read wait" : "R7 R8 read wait", rd, VEC[v][3]);
      repeat (3) @(negedge clk);
    end

    // refresh timing (R2 R3)
    do_reset();
    n = 0;
    for (int i = 1; i <= 1000; i++) begin
      @(negedge clk);
      if (ref_req) begin n = i; break; end
    end
    check("R2 first normal interval", n, 390);
    gap(n);
    check("R2 R3 normal gap after ack", n, 390);
    temp_ext = 1;
    gap(n);
    gap(n);
    check("R2 extended gap", n, 195);

    // postponed refreshes with cke low (R4 R5)
    ref_ack = 1;
    @(negedge clk);
    ref_ack = 0; cmd_valid = 1; cmd_kind = 3;
    @(negedge clk);
    cmd_valid = 0; cmd_kind = 0; cke = 0;
    @(negedge clk);
    repeat (300) @(negedge clk);
    check("R5 held while low", ref_req, 0);
    ref_ack = 1;
    @(negedge clk);
    ref_ack = 0;
    repeat (1646) @(negedge clk);
    cke = 1;
    @(negedge clk);
    @(negedge clk);
    check("R5 released after exit", ref_req, 1);
    cnt = 0;
    while (ref_req && cnt < 20) begin
      ref_ack = 1; cnt++;
      @(negedge clk);
    end
    ref_ack = 0;
    check("R4 saturated owed count", cnt, 8);

    // cke pulse width (R10)
    cke = 0;
    repeat (5) @(negedge clk);
    cke = 1;
    repeat (2) @(negedge clk);
    cke = 0;
    @(negedge clk);
    check("R10 short pulse flagged", cke_viol, 1);
    @(negedge clk);
    check("R10 flag one cycle", cke_viol, 0);
    repeat (5) @(negedge clk);
    cke = 1;
    repeat (3) @(negedge clk);
    cke = 0;
    seen = 0;
    repeat (4) begin
      @(negedge clk);
      if (cke_viol) seen = 1;
    end
    check("R10 legal pulse not flagged", seen, 0);
    cke = 1;
    repeat (4) @(negedge clk);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule